// File: doc/BRIEF.md
# Host-to-DSP Mailbox Port

This block joins an 8-bit host register port to a 24-bit DSP data port. Each direction has one word register and a pair of handshake flags. A word moves across by itself as soon as the flags on both sides allow it. The host sees a small bank of eight byte registers: control, status, command vector, interrupt vector, three data byte lanes and one reserved slot. The DSP side sees its receive and transmit flags, a word read strobe and a word write strobe, the two host flag bits, a command-pending flag and three one-cycle interrupt requests.

A host transmit word can reach the DSP by two routes. The first is direct: the word is loaded into the DSP receive register in the same cycle as the low-byte write, provided the transmit-ready condition holds. The second is held: if the DSP register is occupied, the word waits in the host transmit register until the DSP reads. The host request output is the status condition selected by the control register. A separate host interrupt pulse marks each rising edge of that request.

After reset the DSP core is treated as halted. Each host low-byte write is then sent to a boot write port with an incrementing address. After the last boot word the block reports the core as running, and low-byte writes go back to feeding the mailbox.

Top module: `hdp_port`

## Requirements
- R1: After reset, status reads 0x06 (bit0 receive-full 0, bit1 transmit-empty 1, bit2 transmit-ready 1, bit7 request 0). The command vector reads 0x12 and the interrupt vector reads 0x0F. dsp_txe_o=1, dsp_rxf_o=0 and core_run_o=0. Register addresses: 0 control, 1 status, 2 command vector, 3 interrupt vector, 4/5/6 low/mid/high data byte, 7 reserved.
- R2: While core_run_o=0, a write to address 4 asserts boot_we_o in that cycle. boot_addr_o equals the number of earlier boot writes and boot_data_o={high,mid,low} with the new low byte. After BOOT_WORDS (512) writes, core_run_o=1 and further writes produce no boot write.
- R3: While running, a low-byte write with transmit-ready set loads the assembled word into the DSP receive register. From the next cycle dsp_rxf_o=1, dsp_rdata_o holds the word, transmit-empty stays 1 and transmit-ready reads 0.
- R4: A low-byte write made while dsp_rxf_o=1 clears transmit-empty and holds the word. The DSP read that empties the receive register moves the held word in at the same edge, so dsp_rxf_o stays 1 with the new word and transmit-empty returns to 1.
- R5: A DSP write while host receive-full is 0 sets receive-full from the next cycle, places the word on read addresses 4/5/6 and leaves dsp_txe_o=1. If receive-full is already 1, dsp_txe_o drops to 0 and the word waits. The host read of address 4 that frees the receive register moves the waiting word at that edge.
- R6: Status bit2 (transmit-ready) always equals bit1 AND NOT dsp_rxf_o.
- R7: Status bit7 and host_req_o equal the OR of (control[1:0] AND status[1:0]). host_irq_o is high for exactly one cycle when that condition rises.
- R8: A control write stores the value ANDed with 0xFB. Control bits 4:3 appear on dsp_hflag_o.
- R9: A command vector write stores the value ANDed with 0x9F. Bit7=1 sets dsp_cmd_pend_o and, if dsp_cmd_ie_i=1, pulses dsp_cmd_irq_o for one cycle. Bit7=0 clears dsp_cmd_pend_o.
- R10: dsp_rx_irq_o pulses for one cycle on every host-to-DSP move when dsp_rx_ie_i=1, and stays 0 when the enable is 0. dsp_tx_irq_o does the same for DSP-to-host moves with dsp_tx_ie_i.
- R11: Writes to address 1 and address 7 change no register or flag. Address 7 reads 0.
- R12: The interrupt vector register reads back the last value written to address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 3 | Host register address |
| host_wr_i | input | 1 | Host write strobe, one cycle |
| host_rd_i | input | 1 | Host read strobe, one cycle |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte, combinational on address |
| host_req_o | output | 1 | Host request level |
| host_irq_o | output | 1 | One-cycle pulse on host request rising |
| dsp_wr_i | input | 1 | DSP transmit word write strobe |
| dsp_wdata_i | input | DATA_W | DSP transmit word |
| dsp_rd_i | input | 1 | DSP receive word read strobe |
| dsp_rdata_o | output | DATA_W | DSP receive word |
| dsp_rxf_o | output | 1 | DSP receive register full |
| dsp_txe_o | output | 1 | DSP transmit register empty |
| dsp_rx_ie_i | input | 1 | Enable for receive interrupt |
| dsp_tx_ie_i | input | 1 | Enable for transmit interrupt |
| dsp_cmd_ie_i | input | 1 | Enable for command interrupt |
| dsp_rx_irq_o | output | 1 | Receive interrupt pulse |
| dsp_tx_irq_o | output | 1 | Transmit interrupt pulse |
| dsp_cmd_irq_o | output | 1 | Command interrupt pulse |
| dsp_cmd_pend_o | output | 1 | Host command pending |
| dsp_hflag_o | output | 2 | Host flag bits from control[4:3] |
| boot_we_o | output | 1 | Boot program write enable |
| boot_addr_o | output | BOOT_AW | Boot program address |
| boot_data_o | output | DATA_W | Boot program word |
| core_run_o | output | 1 | Boot complete, core running |

## Verification
The assertions assume well-behaved callers. The DSP issues a read only while dsp_rxf_o is high and a write only while dsp_txe_o is high. The host issues at most one strobe per cycle and never rewrites data bytes while its transmit word is still held. The stimulus keeps to these rules: each access is a single-cycle strobe issued from a task, and every wait for a flag is checked before the next access is made. Under these conditions the stability and no-stall properties hold without conditions on the inputs. The bench sweeps all 512 boot slots and many word patterns in both directions, plus the held-path cases.

// File: rtl/hdp_pkg.sv
package hdp_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0, A_STAT = 3'd1, A_CMD = 3'd2, A_VEC = 3'd3,
    A_LO   = 3'd4, A_MID  = 3'd5, A_HI  = 3'd6, A_RSV = 3'd7
  } hreg_e;

  localparam logic [7:0] CTRL_MASK = 8'hFB;
  localparam logic [7:0] CMD_MASK  = 8'h9F;
  localparam logic [7:0] CMD_RST   = 8'h12;
  localparam logic [7:0] VEC_RST   = 8'h0F;

  localparam int ST_RXF  = 0;
  localparam int ST_TXE  = 1;
  localparam int ST_TRDY = 2;
  localparam int ST_HREQ = 7;
  localparam int CTRL_HF = 3;
  localparam int CMD_GO  = 7;
endpackage

// File: rtl/hdp_xfer.sv
module hdp_xfer #(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              h_load_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic              h_ack_i,
  input  logic              d_rd_i,
  input  logic              d_wr_i,
  input  logic [DATA_W-1:0] d_wdata_i,
  input  logic              rx_ie_i,
  input  logic              tx_ie_i,
  output logic [DATA_W-1:0] h_rx_word_o,
  output logic              h_rxf_o,
  output logic              h_txe_o,
  output logic              h_trdy_o,
  output logic              d_rxf_o,
  output logic              d_txe_o,
  output logic [DATA_W-1:0] d_word_o,
  output logic              d_rx_irq_o,
  output logic              d_tx_irq_o
);
  logic              hrxf_q, htxe_q, drxf_q, dtxe_q, rxirq_q, txirq_q;
  logic [DATA_W-1:0] hrx_q, htx_q, drx_q, dtx_q;
  logic              hrxf_n, htxe_n, drxf_n, dtxe_n, rxirq_n, txirq_n;
  logic [DATA_W-1:0] hrx_n, htx_n, drx_n, dtx_n;

  always_comb begin
    hrxf_n = hrxf_q; htxe_n = htxe_q; drxf_n = drxf_q; dtxe_n = dtxe_q;
    hrx_n  = hrx_q;  htx_n  = htx_q;  drx_n  = drx_q;  dtx_n  = dtx_q;
    rxirq_n = 1'b0;  txirq_n = 1'b0;
    // side events first, then the automatic moves see the updated flags
    if (d_rd_i)  drxf_n = 1'b0;
    if (h_ack_i) hrxf_n = 1'b0;
    if (d_wr_i) begin
      dtxe_n = 1'b0;
      dtx_n  = d_wdata_i;
    end
    if (h_load_i) begin
      if (htxe_n && !drxf_n) begin
        drx_n   = tx_word_i;
        drxf_n  = 1'b1;
        rxirq_n = rx_ie_i;
      end else begin
        htxe_n = 1'b0;
        htx_n  = tx_word_i;
      end
    end
    if (!htxe_n && !drxf_n) begin
      drx_n   = htx_n;
      drxf_n  = 1'b1;
      htxe_n  = 1'b1;
      rxirq_n = rx_ie_i;
    end
    if (!dtxe_n && !hrxf_n) begin
      hrx_n   = dtx_n;
      hrxf_n  = 1'b1;
      dtxe_n  = 1'b1;
      txirq_n = tx_ie_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hrxf_q <= 1'b0; htxe_q <= 1'b1; drxf_q <= 1'b0; dtxe_q <= 1'b1;
      hrx_q  <= '0;   htx_q  <= '0;   drx_q  <= '0;   dtx_q  <= '0;
      rxirq_q <= 1'b0; txirq_q <= 1'b0;
    end else begin
      hrxf_q <= hrxf_n; htxe_q <= htxe_n; drxf_q <= drxf_n; dtxe_q <= dtxe_n;
      hrx_q  <= hrx_n;  htx_q  <= htx_n;  drx_q  <= drx_n;  dtx_q  <= dtx_n;
      rxirq_q <= rxirq_n; txirq_q <= txirq_n;
    end
  end

  assign h_rx_word_o = hrx_q;
  assign h_rxf_o     = hrxf_q;
  assign h_txe_o     = htxe_q;
  assign h_trdy_o    = htxe_q & ~drxf_q;
  assign d_rxf_o     = drxf_q;
  assign d_txe_o     = dtxe_q;
  assign d_word_o    = drx_q;
  assign d_rx_irq_o  = rxirq_q;
  assign d_tx_irq_o  = txirq_q;

  AST_HRX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hrxf_q && !h_ack_i |=> $stable(hrx_q)); // R5
  AST_DRX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drxf_q && !d_rd_i |=> $stable(drx_q)); // R4
  AST_NO_STALL_H2D: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> (htxe_q || drxf_q)); // R4
  AST_NO_STALL_D2H: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> (dtxe_q || hrxf_q)); // R5
  AST_DIRECT_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_load_i && h_trdy_o |=> d_rxf_o && h_txe_o && d_word_o == $past(tx_word_i)); // R3
endmodule

// File: rtl/hdp_host_regs.sv
module hdp_host_regs
  import hdp_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [DATA_W-1:0] rx_word_i,
  input  logic              rxf_i,
  input  logic              txe_i,
  input  logic              trdy_i,
  input  logic              run_i,
  input  logic              cmd_ie_i,
  output logic [DATA_W-1:0] tx_word_o,
  output logic              load_o,
  output logic              boot_wr_o,
  output logic              ack_o,
  output logic              req_o,
  output logic              irq_o,
  output logic [1:0]        hflag_o,
  output logic              cmd_pend_o,
  output logic              cmd_irq_o
);
  localparam int NB = DATA_W / 8;

  logic [7:0]         ctrl_q, cmd_q, vec_q;
  logic               req_d_q, cmd_pend_q, cmd_irq_q;
  logic [NB-1:0][7:0] tx_q;
  logic [7:0]         stat;
  logic [2:0]         lane;
  logic               lo_wr;

  assign lo_wr = wr_i && (addr_i == A_LO);

  for (genvar j = 0; j < NB; j++) begin : g_lane
    logic hit;
    assign hit = wr_i && (addr_i == 3'(int'(A_LO) + j));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  tx_q[j] <= '0;
      else if (hit) tx_q[j] <= wdata_i;
    end
    assign tx_word_o[8*j +: 8] = hit ? wdata_i : tx_q[j];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      cmd_q      <= CMD_RST;
      vec_q      <= VEC_RST;
      req_d_q    <= 1'b0;
      cmd_pend_q <= 1'b0;
      cmd_irq_q  <= 1'b0;
    end else begin
      req_d_q   <= req_o;
      cmd_irq_q <= 1'b0;
      if (wr_i) begin
        unique case (addr_i)
          A_CTRL: ctrl_q <= wdata_i & CTRL_MASK;
          A_CMD: begin
            cmd_q      <= wdata_i & CMD_MASK;
            cmd_pend_q <= wdata_i[CMD_GO];
            cmd_irq_q  <= wdata_i[CMD_GO] & cmd_ie_i;
          end
          A_VEC:  vec_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign req_o = |(ctrl_q[1:0] & {txe_i, rxf_i});
  assign irq_o = req_o & ~req_d_q;

  always_comb begin
    stat          = '0;
    stat[ST_RXF]  = rxf_i;
    stat[ST_TXE]  = txe_i;
    stat[ST_TRDY] = trdy_i;
    stat[ST_HREQ] = req_o;
  end

  assign lane = addr_i - A_LO;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: rdata_o = ctrl_q;
      A_STAT: rdata_o = stat;
      A_CMD:  rdata_o = cmd_q;
      A_VEC:  rdata_o = vec_q;
      default: if (addr_i >= A_LO && int'(lane) < NB) rdata_o = rx_word_i[8*lane +: 8];
    endcase
  end

  assign load_o     = lo_wr & run_i;
  assign boot_wr_o  = lo_wr & ~run_i;
  assign ack_o      = rd_i && (addr_i == A_LO);
  assign hflag_o    = ctrl_q[CTRL_HF +: 2];
  assign cmd_pend_o = cmd_pend_q;
  assign cmd_irq_o  = cmd_irq_q;

  AST_CTRL_BIT2_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> !ctrl_q[2]); // R8
  AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R7
  AST_CMD_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == A_CMD |=> cmd_pend_o == $past(wdata_i[CMD_GO])); // R9
endmodule

// File: rtl/hdp_boot.sv
module hdp_boot #(
  parameter int WORDS  = 512,
  parameter int DATA_W = 24,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              we_o,
  output logic [AW-1:0]     addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              run_o
);
  logic [AW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (wr_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == AW'(WORDS - 1)) run_q <= 1'b1;
    end
  end

  assign we_o   = wr_i;
  assign addr_o = cnt_q;
  assign data_o = word_i;
  assign run_o  = run_q;

  AST_RUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> run_q); // R2
  AST_BOOT_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o && cnt_q != AW'(WORDS - 1) |=> !run_q); // R2
endmodule

// File: rtl/hdp_port.sv
module hdp_port #(
  parameter int DATA_W     = 24,
  parameter int BOOT_WORDS = 512,
  localparam int BOOT_AW   = $clog2(BOOT_WORDS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         host_addr_i,
  input  logic               host_wr_i,
  input  logic               host_rd_i,
  input  logic [7:0]         host_wdata_i,
  output logic [7:0]         host_rdata_o,
  output logic               host_req_o,
  output logic               host_irq_o,
  input  logic               dsp_wr_i,
  input  logic [DATA_W-1:0]  dsp_wdata_i,
  input  logic               dsp_rd_i,
  output logic [DATA_W-1:0]  dsp_rdata_o,
  output logic               dsp_rxf_o,
  output logic               dsp_txe_o,
  input  logic               dsp_rx_ie_i,
  input  logic               dsp_tx_ie_i,
  input  logic               dsp_cmd_ie_i,
  output logic               dsp_rx_irq_o,
  output logic               dsp_tx_irq_o,
  output logic               dsp_cmd_irq_o,
  output logic               dsp_cmd_pend_o,
  output logic [1:0]         dsp_hflag_o,
  output logic               boot_we_o,
  output logic [BOOT_AW-1:0] boot_addr_o,
  output logic [DATA_W-1:0]  boot_data_o,
  output logic               core_run_o
);
  logic [DATA_W-1:0] tx_word, rx_word;
  logic              load, boot_wr, ack, rxf, txe, trdy, run;

  hdp_host_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .addr_i(host_addr_i), .wr_i(host_wr_i), .rd_i(host_rd_i),
    .wdata_i(host_wdata_i), .rdata_o(host_rdata_o),
    .rx_word_i(rx_word), .rxf_i(rxf), .txe_i(txe), .trdy_i(trdy),
    .run_i(run), .cmd_ie_i(dsp_cmd_ie_i),
    .tx_word_o(tx_word), .load_o(load), .boot_wr_o(boot_wr), .ack_o(ack),
    .req_o(host_req_o), .irq_o(host_irq_o), .hflag_o(dsp_hflag_o),
    .cmd_pend_o(dsp_cmd_pend_o), .cmd_irq_o(dsp_cmd_irq_o)
  );

  hdp_xfer #(.DATA_W(DATA_W)) u_xfer (
    .clk_i, .rst_ni,
    .h_load_i(load), .tx_word_i(tx_word), .h_ack_i(ack),
    .d_rd_i(dsp_rd_i), .d_wr_i(dsp_wr_i), .d_wdata_i(dsp_wdata_i),
    .rx_ie_i(dsp_rx_ie_i), .tx_ie_i(dsp_tx_ie_i),
    .h_rx_word_o(rx_word), .h_rxf_o(rxf), .h_txe_o(txe), .h_trdy_o(trdy),
    .d_rxf_o(dsp_rxf_o), .d_txe_o(dsp_txe_o), .d_word_o(dsp_rdata_o),
    .d_rx_irq_o(dsp_rx_irq_o), .d_tx_irq_o(dsp_tx_irq_o)
  );

  hdp_boot #(.WORDS(BOOT_WORDS), .DATA_W(DATA_W)) u_boot (
    .clk_i, .rst_ni,
    .wr_i(boot_wr), .word_i(tx_word),
    .we_o(boot_we_o), .addr_o(boot_addr_o), .data_o(boot_data_o),
    .run_o(run)
  );

  assign core_run_o = run;
endmodule

// File: tb/hdp_port_tb_top.sv
`timescale 1ns/1ps
module hdp_port_tb_top;
  localparam int DW = 24;
  localparam int BW = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] h_addr = '0;
  logic h_wr = 1'b0, h_rd = 1'b0;
  logic [7:0] h_wdata = '0;
  logic d_wr = 1'b0, d_rd = 1'b0;
  logic [DW-1:0] d_wdata = '0;
  logic rx_ie = 1'b0, tx_ie = 1'b0, cmd_ie = 1'b0;

  logic [7:0] host_rdata_o;
  logic host_req_o, host_irq_o, dsp_rxf_o, dsp_txe_o;
  logic [DW-1:0] dsp_rdata_o, boot_data_o;
  logic dsp_rx_irq_o, dsp_tx_irq_o, dsp_cmd_irq_o, dsp_cmd_pend_o;
  logic [1:0] dsp_hflag_o;
  logic boot_we_o, core_run_o;
  logic [8:0] boot_addr_o;

  int vectors = 0, miscompares = 0;

  always #2 clk = ~clk;

  hdp_port dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .host_addr_i(h_addr), .host_wr_i(h_wr), .host_rd_i(h_rd), .host_wdata_i(h_wdata),
    .host_rdata_o, .host_req_o, .host_irq_o,
    .dsp_wr_i(d_wr), .dsp_wdata_i(d_wdata), .dsp_rd_i(d_rd), .dsp_rdata_o,
    .dsp_rxf_o, .dsp_txe_o, .dsp_rx_ie_i(rx_ie), .dsp_tx_ie_i(tx_ie),
    .dsp_cmd_ie_i(cmd_ie), .dsp_rx_irq_o, .dsp_tx_irq_o, .dsp_cmd_irq_o,
    .dsp_cmd_pend_o, .dsp_hflag_o, .boot_we_o, .boot_addr_o, .boot_data_o, .core_run_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1'b1;
    @(negedge clk); h_wr = 1'b0;
  endtask

  task automatic hrd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); h_addr = a; h_rd = 1'b1;
    #1 v = host_rdata_o;
    @(negedge clk); h_rd = 1'b0;
  endtask

  task automatic dwr(input logic [DW-1:0] w);
    @(negedge clk); d_wdata = w; d_wr = 1'b1;
    @(negedge clk); d_wr = 1'b0;
  endtask

  task automatic drd(output logic [DW-1:0] v);
    @(negedge clk); d_rd = 1'b1;
    #1 v = dsp_rdata_o;
    @(negedge clk); d_rd = 1'b0;
  endtask

  task automatic send(input logic [DW-1:0] w);
    hwr(3'd6, w[23:16]); hwr(3'd5, w[15:8]); hwr(3'd4, w[7:0]);
  endtask

  function automatic logic [DW-1:0] pat(input int k);
    logic [31:0] t;
    t = k * 32'h0013_579B ^ 32'h00F0_A5C3;
    return t[DW-1:0];
  endfunction

  initial begin
    #(200000 * 4);
    vectors++; miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [DW-1:0] w, v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    hrd(3'd1, b); chk("R1 status", b, 8'h06);
    hrd(3'd2, b); chk("R1 cmd vector", b, 8'h12);
    hrd(3'd3, b); chk("R1 int vector", b, 8'h0F);
    chk("R1 dsp_txe", dsp_txe_o, 1); chk("R1 dsp_rxf", dsp_rxf_o, 0);
    chk("R1 core_run", core_run_o, 0);

    // R2 boot sweep over every slot
    for (int i = 0; i < BW; i++) begin
      w = pat(i + 100);
      hwr(3'd6, w[23:16]); hwr(3'd5, w[15:8]);
      @(negedge clk); h_addr = 3'd4; h_wdata = w[7:0]; h_wr = 1'b1;
      #1;
      chk("R2 boot_we", boot_we_o, 1);
      chk("R2 boot_addr", boot_addr_o, i);
      chk("R2 boot_data", boot_data_o, w);
      @(negedge clk); h_wr = 1'b0;
      if (i < BW - 1) chk("R2 still halted", core_run_o, 0);
    end
    chk("R2 running", core_run_o, 1);
    hrd(3'd1, b); chk("R2 boot left mailbox idle", b, 8'h06);

    // R8 control mask and host flags, R7 rising edge pulse
    hwr(3'd0, 8'hFF);
    chk("R7 irq pulse", host_irq_o, 1); chk("R7 req", host_req_o, 1);
    chk("R8 hflag", dsp_hflag_o, 2'b11);
    hrd(3'd0, b); chk("R8 ctrl masked", b, 8'hFB);
    chk("R7 irq one cycle", host_irq_o, 0);
    hrd(3'd1, b); chk("R7 status bit7", b, 8'h86);
    hwr(3'd0, 8'h08); chk("R8 hflag low", dsp_hflag_o, 2'b01);
    chk("R7 req dropped", host_req_o, 0);
    hwr(3'd0, 8'h00);

    // R3 R10 R6 direct path sweep
    rx_ie = 1'b1;
    for (int k = 0; k < 24; k++) begin
      w = pat(k);
      send(w);
      chk("R3 dsp_rxf", dsp_rxf_o, 1);
      chk("R3 dsp word", dsp_rdata_o, w);
      chk("R10 rx irq", dsp_rx_irq_o, 1);
      hrd(3'd1, b); chk("R6 trdy low while dsp full", b, 8'h02);
      chk("R10 rx irq single", dsp_rx_irq_o, 0);
      drd(v);
      chk("R3 emptied", dsp_rxf_o, 0);
      hrd(3'd1, b); chk("R6 trdy back", b, 8'h06);
    end
    rx_ie = 1'b0;
    send(24'h123456);
    chk("R10 rx irq disabled", dsp_rx_irq_o, 0);

    // R4 held path: dsp still holds 0x123456
    send(24'hABCDEF);
    hrd(3'd1, b); chk("R4 txe cleared", b, 8'h00);
    chk("R4 old word kept", dsp_rdata_o, 24'h123456);
    rx_ie = 1'b1;
    drd(v);
    chk("R4 read old", v, 24'h123456);
    chk("R4 refilled", dsp_rxf_o, 1);
    chk("R4 new word", dsp_rdata_o, 24'hABCDEF);
    chk("R10 rx irq held move", dsp_rx_irq_o, 1);
    hrd(3'd1, b); chk("R4 txe set", b, 8'h02);
    drd(v);
    rx_ie = 1'b0;

    // R5 R10 DSP to host sweep
    tx_ie = 1'b1;
    for (int k = 0; k < 24; k++) begin
      w = pat(k + 40);
      dwr(w);
      chk("R10 tx irq", dsp_tx_irq_o, 1);
      chk("R5 dsp_txe", dsp_txe_o, 1);
      hrd(3'd1, b); chk("R5 rxf set", b, 8'h07);
      hrd(3'd6, b); chk("R5 high byte", b, w[23:16]);
      hrd(3'd5, b); chk("R5 mid byte", b, w[15:8]);
      hrd(3'd4, b); chk("R5 low byte", b, w[7:0]);
      hrd(3'd1, b); chk("R5 rxf cleared", b, 8'h06);
    end

    // R5 hold while host register full
    dwr(24'h111111);
    dwr(24'h222222);
    chk("R5 dsp_txe held", dsp_txe_o, 0);
    chk("R10 no tx irq while waiting", dsp_tx_irq_o, 0);
    hrd(3'd6, b); chk("R5 first word visible", b, 8'h11);
    hrd(3'd4, b); chk("R5 first low", b, 8'h11);
    chk("R5 moved on ack", dsp_txe_o, 1);
    chk("R10 tx irq held move", dsp_tx_irq_o, 1);
    hrd(3'd6, b); chk("R5 second word", b, 8'h22);
    hrd(3'd4, b);
    tx_ie = 1'b0;
    dwr(24'h333333);
    chk("R10 tx irq disabled", dsp_tx_irq_o, 0);

    // R7 request from receive-full
    hwr(3'd0, 8'h01);
    chk("R7 req level rxf", host_req_o, 1);
    chk("R7 irq on rxf", host_irq_o, 1);
    hrd(3'd4, b);
    chk("R7 req drop", host_req_o, 0);
    hrd(3'd1, b); chk("R7 status bit7 clear", b, 8'h06);
    hwr(3'd0, 8'h00);

    // R9 command vector
    cmd_ie = 1'b1;
    hwr(3'd2, 8'hFF);
    chk("R9 cmd irq", dsp_cmd_irq_o, 1); chk("R9 pend", dsp_cmd_pend_o, 1);
    hrd(3'd2, b); chk("R9 cmd masked", b, 8'h9F);
    chk("R9 cmd irq single", dsp_cmd_irq_o, 0);
    hwr(3'd2, 8'h65);
    chk("R9 pend cleared", dsp_cmd_pend_o, 0); chk("R9 no irq", dsp_cmd_irq_o, 0);
    hrd(3'd2, b); chk("R9 cmd value", b, 8'h05);
    cmd_ie = 1'b0;
    hwr(3'd2, 8'h81);
    chk("R9 pend no enable", dsp_cmd_pend_o, 1); chk("R9 irq gated", dsp_cmd_irq_o, 0);

    // R11 ignored writes
    hwr(3'd1, 8'hFF);
    hrd(3'd1, b); chk("R11 status unchanged", b, 8'h06);
    hwr(3'd7, 8'hFF);
    hrd(3'd7, b); chk("R11 reserved reads zero", b, 8'h00);
    hrd(3'd0, b); chk("R11 ctrl unchanged", b, 8'h00);
    chk("R11 dsp side unchanged", {dsp_rxf_o, dsp_txe_o}, 2'b01);

    // R12 interrupt vector
    hwr(3'd3, 8'h3C);
    hrd(3'd3, b); chk("R12 vector", b, 8'h3C);
    hwr(3'd3, 8'hC3);
    hrd(3'd3, b); chk("R12 vector again", b, 8'hC3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule